// File: doc/BRIEF.md
# I2C Target Command and Acknowledge Sequencer

This block is the decision core of an I2C target. It holds the three pending-event flags: data-ready, address-match and stop-received. Software answers an event by writing a two-bit command strobe and an acknowledge-polarity bit. From the command, the pending flags and the current transfer direction, the block decides whether to request an acknowledge drive and with which polarity. It also decides whether to receive the next byte, send a byte, raise data-ready again, or park in a wait-for-start state.

Bit-level SCL/SDA handling, address comparison and data storage live elsewhere. They reach this block as single-cycle event pulses: address matched, byte ready, STOP seen and START seen. A data-register read strobe also comes in. With smart mode on, that read strobe acknowledges a received byte without a command write. When group-command support is enabled, the stop flag is raised only on a STOP that ends a transfer in which this target was addressed.

Top module: `i2c_tgt_ack_seq`

## Requirements
- R1: The command readback port `cmd_rdback` is always zero, including right after a command write.
- R2: Command 2 (binary 10), accepted with host writing (`host_rd`=0), pulses `ack_req` and sets `wait_start`. With host reading (`host_rd`=1) it only sets `wait_start`. `wait_start` clears on `start_ev`.
- R3: Command 3 (binary 11) with address-match pending pulses `ack_req`. It then pulses `rx_next` when the host writes, or sets the data-ready flag when the host reads.
- R4: Command 3 with only data-ready pending pulses `ack_req` and `rx_next` when the host writes. When the host reads it pulses `tx_byte` only, without `ack_req`. `rx_next` and `tx_byte` are never high together.
- R5: When data-ready and address-match are both pending, command 3 follows the address-match path.
- R6: Command 0 (no operation) and command 1 (reserved) produce no output pulse and leave every flag unchanged.
- R7: An accepted command 2 or 3 clears the data-ready, address-match and stop-received flags together. An event arriving in the same cycle still sets its flag.
- R8: A command written while no flag is pending produces no output pulse and changes no state.
- R9: A STOP sets the stop-received flag. If `grp_cmd_en`=1, it does so only if an address match occurred since the previous STOP.
- R10: The addressed-since-stop state is set by an address match and cleared by a STOP. A second STOP without a new match therefore leaves the stop flag clear under group mode.
- R11: With `smart_en`=1, data-ready pending and host writing, a `data_rd` pulse acts as an acknowledge. It pulses `ack_req` and `rx_next` and clears only the data-ready flag. With `smart_en`=0 the read strobe has no effect.
- R12: `ack_nack` carries the acknowledge-action bit captured with the action: 0 means ACK and 1 means NACK.
- R13: `ack_req`, `rx_next` and `tx_byte` are one-cycle pulses, high in the cycle after the triggering write or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | CMD_W | Command code written with `cmd_we` |
| ack_act | input | 1 | Acknowledge action, 0 ACK, 1 NACK |
| smart_en | input | 1 | Smart mode enable |
| grp_cmd_en | input | 1 | Group-command stop qualification enable |
| host_rd | input | 1 | Transfer direction, 1 when the host reads |
| amatch_ev | input | 1 | Address-match event pulse |
| drdy_ev | input | 1 | Data-ready event pulse |
| stop_ev | input | 1 | STOP detected pulse |
| start_ev | input | 1 | START or repeated START detected pulse |
| data_rd | input | 1 | Data register read strobe |
| ack_req | output | 1 | Request to drive the acknowledge bit |
| ack_nack | output | 1 | Acknowledge level to drive, 1 NACK |
| rx_next | output | 1 | Request to receive the next byte |
| tx_byte | output | 1 | Request to send a byte and sample the host acknowledge |
| wait_start | output | 1 | Waiting for a START condition |
| drdy_flag | output | 1 | Data-ready flag |
| amatch_flag | output | 1 | Address-match flag |
| prec_flag | output | 1 | Stop-received flag |
| cmd_rdback | output | CMD_W | Command field readback, always zero |

## Verification
The main function is tried with every pairing of command code, pending flag and direction. These cases separate the address-match path from the data-ready path, and the acknowledge-then-receive outcome from the send-byte outcome. One pattern has both flags pending and host reading, where the two paths give visibly different outputs; this pins down the priority. Commands 0 and 1 are written with a flag pending, and command 3 with no flag pending, so ignored writes are seen to leave flags and pulses untouched. STOP sequences with and without a prior address match, under group mode on and off, separate the qualified stop flag from the unqualified one. A smart-mode read, with the mode on and then off, shows the read strobe acknowledging only when enabled.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [1:0] {
      TCMD_NOP  = 2'd0,
      TCMD_RSVD = 2'd1,
      TCMD_DONE = 2'd2,
      TCMD_NEXT = 2'd3
   } tcmd_e;

   typedef struct packed {
      logic clr_all;
      logic clr_drdy;
      logic ack;
      logic rx;
      logic tx;
      logic set_drdy;
      logic set_wait;
   } tact_t;
endpackage

// File: rtl/i2c_tgt_cmd_dec.sv
module i2c_tgt_cmd_dec
   import i2c_tgt_pkg::*;
#(
   parameter int CMD_W = 2
) (
   input  logic             cmd_we,
   input  logic [CMD_W-1:0] cmd_code,
   input  logic             host_rd,
   input  logic             drdy,
   input  logic             amatch,
   input  logic             prec,
   input  logic             smart_rd,
   output tact_t            act
);
   logic  pend;
   tcmd_e cmd;

   assign pend = drdy | amatch | prec;
   assign cmd  = tcmd_e'(cmd_code[1:0]);

   always_comb begin
      act = '0;
      if (cmd_we && pend) begin
         case (cmd)
            TCMD_DONE: begin
               act.clr_all  = 1'b1;
               act.set_wait = 1'b1;
               act.ack      = ~host_rd;
            end
            TCMD_NEXT: begin
               act.clr_all = 1'b1;
               if (amatch) begin
                  act.ack = 1'b1;
                  if (host_rd) act.set_drdy = 1'b1;
                  else         act.rx       = 1'b1;
               end else if (drdy) begin
                  if (host_rd) act.tx = 1'b1;
                  else begin
                     act.ack = 1'b1;
                     act.rx  = 1'b1;
                  end
               end
            end
            default: act = '0;
         endcase
      end else if (smart_rd) begin
         act.clr_drdy = 1'b1;
         act.ack      = 1'b1;
         act.rx       = 1'b1;
      end
   end
endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_all,
   input  logic clr_drdy,
   input  logic set_drdy,
   input  logic drdy_ev,
   input  logic amatch_ev,
   input  logic stop_ev,
   input  logic grp_en,
   output logic drdy,
   output logic amatch,
   output logic prec,
   output logic addressed
);
   logic stop_qual;

   assign stop_qual = stop_ev & (~grp_en | addressed);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drdy      <= 1'b0;
         amatch    <= 1'b0;
         prec      <= 1'b0;
         addressed <= 1'b0;
      end else begin
         drdy      <= (drdy & ~clr_all & ~clr_drdy) | drdy_ev | set_drdy;
         amatch    <= (amatch & ~clr_all) | amatch_ev;
         prec      <= (prec & ~clr_all) | stop_qual;
         addressed <= amatch_ev | (addressed & ~stop_ev);
      end
   end
endmodule

// File: rtl/i2c_tgt_ack_seq.sv
module i2c_tgt_ack_seq
   import i2c_tgt_pkg::*;
#(
   parameter int CMD_W         = 2,
   parameter bit SMART_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [CMD_W-1:0] cmd_code,
   input  logic             ack_act,
   input  logic             smart_en,
   input  logic             grp_cmd_en,
   input  logic             host_rd,
   input  logic             amatch_ev,
   input  logic             drdy_ev,
   input  logic             stop_ev,
   input  logic             start_ev,
   input  logic             data_rd,
   output logic             ack_req,
   output logic             ack_nack,
   output logic             rx_next,
   output logic             tx_byte,
   output logic             wait_start,
   output logic             drdy_flag,
   output logic             amatch_flag,
   output logic             prec_flag,
   output logic [CMD_W-1:0] cmd_rdback
);
   generate
      if (CMD_W != 2) begin : g_bad_width
         $error("i2c_tgt_ack_seq: CMD_W must be 2");
      end
   endgenerate

   tact_t act;
   logic  smart_rd;
   logic  addressed_w;

   generate
      if (SMART_SUPPORT) begin : g_smart
         assign smart_rd = smart_en & data_rd & drdy_flag & ~host_rd;
      end else begin : g_no_smart
         assign smart_rd = 1'b0;
      end
   endgenerate

   i2c_tgt_cmd_dec #(.CMD_W(CMD_W)) u_dec (
      .cmd_we   (cmd_we),
      .cmd_code (cmd_code),
      .host_rd  (host_rd),
      .drdy     (drdy_flag),
      .amatch   (amatch_flag),
      .prec     (prec_flag),
      .smart_rd (smart_rd),
      .act      (act)
   );

   i2c_tgt_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_all   (act.clr_all),
      .clr_drdy  (act.clr_drdy),
      .set_drdy  (act.set_drdy),
      .drdy_ev   (drdy_ev),
      .amatch_ev (amatch_ev),
      .stop_ev   (stop_ev),
      .grp_en    (grp_cmd_en),
      .drdy      (drdy_flag),
      .amatch    (amatch_flag),
      .prec      (prec_flag),
      .addressed (addressed_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_req    <= 1'b0;
         ack_nack   <= 1'b0;
         rx_next    <= 1'b0;
         tx_byte    <= 1'b0;
         wait_start <= 1'b0;
      end else begin
         ack_req    <= act.ack;
         if (act.ack) ack_nack <= ack_act;
         rx_next    <= act.rx;
         tx_byte    <= act.tx;
         wait_start <= act.set_wait | (wait_start & ~start_ev);
      end
   end

   assign cmd_rdback = '0;
endmodule

// File: rtl/i2c_tgt_ack_seq_chk.sv
module i2c_tgt_ack_seq_chk #(
   parameter int CMD_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_we,
   input logic [CMD_W-1:0] cmd_code,
   input logic             data_rd,
   input logic             amatch_ev,
   input logic             stop_ev,
   input logic             grp_cmd_en,
   input logic             ack_req,
   input logic             rx_next,
   input logic             tx_byte,
   input logic             wait_start,
   input logic             drdy_flag,
   input logic             amatch_flag,
   input logic             prec_flag,
   input logic             addressed
);
   assert_rx_tx_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_next && tx_byte));

   assert_idle_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !drdy_flag && !amatch_flag && !prec_flag && !data_rd)
      |=> (!ack_req && !rx_next && !tx_byte));

   assert_nop_rsvd_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !cmd_code[1] && !data_rd) |=> (!ack_req && !rx_next && !tx_byte));

   assert_wait_from_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wait_start) |-> ($past(cmd_we) && $past(cmd_code) == 2'd2));

   assert_stop_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prec_flag) |-> ($past(stop_ev) && (!$past(grp_cmd_en) || $past(addressed))));

   assert_cmd_clears_amatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_code[1] && (drdy_flag || amatch_flag || prec_flag))
      |=> (!amatch_flag || $past(amatch_ev)));
endmodule

bind i2c_tgt_ack_seq i2c_tgt_ack_seq_chk #(.CMD_W(CMD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_we      (cmd_we),
   .cmd_code    (cmd_code),
   .data_rd     (data_rd),
   .amatch_ev   (amatch_ev),
   .stop_ev     (stop_ev),
   .grp_cmd_en  (grp_cmd_en),
   .ack_req     (ack_req),
   .rx_next     (rx_next),
   .tx_byte     (tx_byte),
   .wait_start  (wait_start),
   .drdy_flag   (drdy_flag),
   .amatch_flag (amatch_flag),
   .prec_flag   (prec_flag),
   .addressed   (addressed_w)
);

// File: tb/i2c_tgt_ack_seq_bench.sv
module i2c_tgt_ack_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_we = 1'b0;
   logic [1:0] cmd_code = 2'd0;
   logic       ack_act = 1'b0, smart_en = 1'b0, grp_cmd_en = 1'b0, host_rd = 1'b0;
   logic       amatch_ev = 1'b0, drdy_ev = 1'b0, stop_ev = 1'b0, start_ev = 1'b0;
   logic       data_rd = 1'b0;
   logic       ack_req, ack_nack, rx_next, tx_byte, wait_start;
   logic       drdy_flag, amatch_flag, prec_flag;
   logic [1:0] cmd_rdback;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2c_tgt_ack_seq u_i2c_tgt_ack_seq (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
      .ack_act(ack_act), .smart_en(smart_en), .grp_cmd_en(grp_cmd_en),
      .host_rd(host_rd), .amatch_ev(amatch_ev), .drdy_ev(drdy_ev),
      .stop_ev(stop_ev), .start_ev(start_ev), .data_rd(data_rd),
      .ack_req(ack_req), .ack_nack(ack_nack), .rx_next(rx_next),
      .tx_byte(tx_byte), .wait_start(wait_start), .drdy_flag(drdy_flag),
      .amatch_flag(amatch_flag), .prec_flag(prec_flag), .cmd_rdback(cmd_rdback)
   );

   // {amatch,drdy,host_rd,cmd[1:0],ack_act}_{ack_req,nack,rx,tx,wait,drdy,amatch}_{req id}
   localparam int NV = 10;
   localparam logic [16:0] VEC [NV] = '{
      17'b010101_1100100_0010, // R2 done, host write, NACK
      17'b011100_0000100_0010, // R2 done, host read
      17'b100111_1110000_0011, // R3 amatch, host write
      17'b101110_1000010_0011, // R3 amatch, host read
      17'b010110_1010000_0100, // R4 drdy, host write, ACK (R12)
      17'b011111_0001000_0100, // R4 drdy, host read
      17'b111110_1000010_0101, // R5 both pending, host read
      17'b010000_0000010_0110, // R6 nop keeps drdy
      17'b100010_0000001_0110, // R6 reserved keeps amatch
      17'b000110_0000000_1000  // R8 no flag pending
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse_cycle();
      @(negedge clk);
      {cmd_we, amatch_ev, drdy_ev, stop_ev, start_ev, data_rd} = '0;
   endtask

   task automatic write_cmd(input logic [1:0] c);
      cmd_code = c;
      cmd_we   = 1'b1;
      pulse_cycle();
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 and reset state
      chk("R1 readback at reset", {30'd0, cmd_rdback}, 0);
      chk("reset outputs", {ack_req, rx_next, tx_byte, wait_start, drdy_flag, amatch_flag, prec_flag}, 0);

      for (int i = 0; i < NV; i++) begin
         logic [16:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d vector %0d", v[3:0], i);
         do_reset();
         host_rd   = v[14];
         ack_act   = v[11];
         amatch_ev = v[16];
         drdy_ev   = v[15];
         pulse_cycle();
         write_cmd(v[13:12]);
         chk({tag, " ack_req"}, ack_req, v[10]);
         if (v[10]) chk({tag, " ack_nack R12"}, ack_nack, v[9]);
         chk({tag, " rx_next"}, rx_next, v[8]);
         chk({tag, " tx_byte"}, tx_byte, v[7]);
         chk({tag, " wait_start"}, wait_start, v[6]);
         chk({tag, " drdy R7"}, drdy_flag, v[5]);
         chk({tag, " amatch R7"}, amatch_flag, v[4]);
         chk({tag, " prec"}, prec_flag, 0);
         chk({tag, " R1 readback"}, {30'd0, cmd_rdback}, 0);
         pulse_cycle();
         chk({tag, " R13 pulses drop"}, {ack_req, rx_next, tx_byte}, 0);
      end

      // R2: wait_start cleared by START
      do_reset();
      host_rd = 1'b0;
      drdy_ev = 1'b1;
      pulse_cycle();
      write_cmd(2'd2);
      chk("R2 wait set", wait_start, 1);
      start_ev = 1'b1;
      pulse_cycle();
      chk("R2 wait cleared by start", wait_start, 0);

      // R9, R10 group-command stop qualification
      do_reset();
      grp_cmd_en = 1'b1;
      stop_ev = 1'b1;
      pulse_cycle();
      chk("R9 stop without address", prec_flag, 0);
      amatch_ev = 1'b1;
      pulse_cycle();
      stop_ev = 1'b1;
      pulse_cycle();
      chk("R9 stop after address", prec_flag, 1);
      write_cmd(2'd2);
      chk("R7 command clears prec", {prec_flag, amatch_flag}, 0);
      start_ev = 1'b1;
      pulse_cycle();
      stop_ev = 1'b1;
      pulse_cycle();
      chk("R10 second stop unaddressed", prec_flag, 0);
      grp_cmd_en = 1'b0;
      stop_ev = 1'b1;
      pulse_cycle();
      chk("R9 stop with group off", prec_flag, 1);

      // R11 smart mode
      do_reset();
      smart_en = 1'b1;
      host_rd  = 1'b0;
      ack_act  = 1'b1;
      drdy_ev  = 1'b1;
      pulse_cycle();
      amatch_ev = 1'b1;
      pulse_cycle();
      data_rd = 1'b1;
      pulse_cycle();
      chk("R11 smart ack/rx", {ack_req, ack_nack, rx_next}, 3'b111);
      chk("R11 smart clears drdy only", {drdy_flag, amatch_flag}, 2'b01);
      do_reset();
      smart_en = 1'b0;
      drdy_ev  = 1'b1;
      pulse_cycle();
      data_rd = 1'b1;
      pulse_cycle();
      chk("R11 smart off ignored", {ack_req, rx_next, drdy_flag}, 3'b001);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule